// File: doc/BRIEF.md
# Streaming Source/Sink Master for a Synchronous FIFO Bridge Bus

This block is the master side of a synchronous parallel FIFO bus, the kind a USB-to-FIFO bridge exposes. The bridge supplies the bus clock and two active-low status flags. One flag says the receive direction (host to device) holds data. The other says the transmit direction (device to host) has room.

The master works as a traffic endpoint. Whenever the receive flag is asserted, it empties the bridge in one continuous read burst. It compares every word against an expected incrementing sequence and keeps a saturating count of mismatches. Whenever the transmit flag shows space, it fills the bridge from a free-running 32-bit incrementing counter.

A write burst can be cut at any word count through a length input. The bridge then ships the partial buffer as a short packet. When both directions are pending at the same moment, the master alternates between them.

The data bus is bidirectional and carries byte enables. The master drives it only while writing. Before any read it leaves the bus released for a command interval and a turnaround cycle.

Top module: `fbm_stream_master`

## Requirements
- R1: During and right after reset, `wr_n`, `rd_n` and `oe_n` are high and `err_count`, `rx_words` and `tx_words` are zero.
- R2: A read burst starts from idle. The first `rd_n` low falls exactly 4 cycles after the cycle in which the idle master sees `rxf_n` low: 1 idle, 2 command and 1 turnaround cycle. `oe_n` goes low in that same cycle and never before it, and `rd_n` is low only while `oe_n` is low.
- R3: Once started, a read burst keeps `rd_n` low in every cycle that `rxf_n` stays low. All data offered without a gap is taken in a single burst.
- R4: `rd_n` rises in the same cycle that `rxf_n` rises. A word presented in a cycle with `rxf_n` high is neither counted in `rx_words` nor compared.
- R5: Each accepted read word is compared with the low `DATA_W` bits of an expected counter that starts at 0 and advances once per accepted word. Each mismatch raises `err_count` by exactly one.
- R6: `err_count` saturates at 2^`ERR_W`-1 and stays there under further mismatches.
- R7: Written words carry the low `DATA_W` bits of a counter that starts at 0 and advances once per accepted word, with all byte enables high. `tx_words` equals the number of accepted words.
- R8: A write burst ends after `burst_len` words, or after `BURST_MAX` words when `burst_len` is 0. The rest follows in later bursts, and the last one may be shorter.
- R9: `wr_n` rises in the same cycle that `txe_n` rises, and the word on the bus in that cycle is not counted.
- R10: When both flags are low at idle, the master picks the direction opposite to its previous burst. The first choice after reset is read.
- R11: `oe_n` and `wr_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock from the bridge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxf_n | input | 1 | Low while the bridge holds receive data |
| txe_n | input | 1 | Low while the bridge has transmit space |
| burst_len | input | LEN_W | Write burst word limit, 0 selects BURST_MAX |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| oe_n | output | 1 | Asks the bridge to drive the bus, active low |
| data_io | inout | DATA_W | Bidirectional data bus |
| be_io | inout | DATA_W/8 | Bidirectional byte enables |
| err_count | output | ERR_W | Saturating mismatch count |
| rx_words | output | 32 | Accepted read words |
| tx_words | output | 32 | Accepted write words |

## Verification
The hardest case to reach is a flag rising in the middle of a burst. Here the strobe has to fall in that same cycle, and the word still on the bus must be dropped.

The bridge model in the bench handles this with two measures. It releases data and space in small quantities, so its flags rise while the master is inside a burst. In every cycle with nothing available, it presents a deliberately wrong word. Any word the master wrongly accepts therefore shows up at the ports, either as an error count or as a break in the written sequence.

Both flags are also lowered in the same cycle, several times over, to exercise the alternation between directions.

// File: rtl/fbm_pkg.sv
package fbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RCMD = 3'd1,
        ST_RTA  = 3'd2,
        ST_RDAT = 3'd3,
        ST_WDAT = 3'd4
    } fbm_state_e;

endpackage

// File: rtl/fbm_seq.sv
module fbm_seq
    import fbm_pkg::*;
#(
    parameter int CMD_CYCLES = 2,
    parameter int BURST_MAX  = 1024,
    parameter int LEN_W      = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxf_n,
    input  logic             txe_n,
    input  logic [LEN_W-1:0] burst_len,
    output logic             rd_n,
    output logic             wr_n,
    output logic             oe_n,
    output logic             drive_en,
    output logic             rd_take,
    output logic             wr_take
);
    localparam int CW = (CMD_CYCLES > 1) ? $clog2(CMD_CYCLES) : 1;

    typedef struct packed {
        fbm_state_e       state;
        logic [CW-1:0]    cmd;
        logic [LEN_W-1:0] beat;
        logic             last_rd;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [LEN_W-1:0] limit;
    logic             want_rd, want_wr;

    always_comb begin
        seq_d   = seq_q;
        limit   = (burst_len == '0) ? LEN_W'(BURST_MAX) : burst_len;
        want_rd = !rxf_n;
        want_wr = !txe_n;
        rd_take = (seq_q.state == ST_RDAT) && !rxf_n;
        wr_take = (seq_q.state == ST_WDAT) && !txe_n;

        case (seq_q.state)
            ST_IDLE: begin
                if (want_rd && (!want_wr || !seq_q.last_rd)) begin
                    seq_d.state   = ST_RCMD;
                    seq_d.cmd     = '0;
                    seq_d.last_rd = 1'b1;
                end else if (want_wr) begin
                    seq_d.state   = ST_WDAT;
                    seq_d.beat    = '0;
                    seq_d.last_rd = 1'b0;
                end
            end
            ST_RCMD: begin
                if (seq_q.cmd == CW'(CMD_CYCLES - 1)) begin
                    seq_d.state = ST_RTA;
                end else begin
                    seq_d.cmd = seq_q.cmd + 1'b1;
                end
            end
            ST_RTA: begin
                seq_d.state = ST_RDAT;
            end
            ST_RDAT: begin
                if (rxf_n) begin
                    seq_d.state = ST_IDLE;
                end
            end
            ST_WDAT: begin
                if (txe_n) begin
                    seq_d.state = ST_IDLE;
                end else if (seq_q.beat + 1'b1 == limit) begin
                    seq_d.state = ST_IDLE;
                end else begin
                    seq_d.beat = seq_q.beat + 1'b1;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase

        oe_n     = !(seq_q.state == ST_RDAT);
        rd_n     = !rd_take;
        wr_n     = !wr_take;
        drive_en = (seq_q.state == ST_WDAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, cmd: '0, beat: '0, last_rd: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/fbm_tx_pattern.sv
module fbm_tx_pattern #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    output logic [DW-1:0] data_o,
    output logic [31:0]   count_o
);
    typedef struct packed {
        logic [31:0] cnt;
    } txp_t;

    txp_t txp_d, txp_q;

    always_comb begin
        txp_d = txp_q;
        if (take) begin
            txp_d.cnt = txp_q.cnt + 32'd1;
        end
        data_o  = txp_q.cnt[DW-1:0];
        count_o = txp_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txp_q <= '0;
        end else begin
            txp_q <= txp_d;
        end
    end

endmodule

// File: rtl/fbm_rx_check.sv
module fbm_rx_check #(
    parameter int DW    = 32,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [DW-1:0]    data_i,
    output logic [ERR_W-1:0] err_o,
    output logic [31:0]      words_o
);
    typedef struct packed {
        logic [31:0]      expect_cnt;
        logic [ERR_W-1:0] err;
    } rxc_t;

    rxc_t rxc_d, rxc_q;
    logic mismatch;

    always_comb begin
        rxc_d    = rxc_q;
        mismatch = (data_i != rxc_q.expect_cnt[DW-1:0]);
        if (take) begin
            rxc_d.expect_cnt = rxc_q.expect_cnt + 32'd1;
            if (mismatch && (rxc_q.err != '1)) begin
                rxc_d.err = rxc_q.err + 1'b1;
            end
        end
        err_o   = rxc_q.err;
        words_o = rxc_q.expect_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxc_q <= '0;
        end else begin
            rxc_q <= rxc_d;
        end
    end

endmodule

// File: rtl/fbm_stream_master.sv
module fbm_stream_master #(
    parameter int  DATA_W     = 32,
    parameter int  BURST_MAX  = 1024,
    parameter int  CMD_CYCLES = 2,
    parameter int  ERR_W      = 8,
    localparam int LEN_W      = $clog2(BURST_MAX + 1),
    localparam int BE_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxf_n,
    input  logic              txe_n,
    input  logic [LEN_W-1:0]  burst_len,
    output logic              wr_n,
    output logic              rd_n,
    output logic              oe_n,
    inout  wire  [DATA_W-1:0] data_io,
    inout  wire  [BE_W-1:0]   be_io,
    output logic [ERR_W-1:0]  err_count,
    output logic [31:0]       rx_words,
    output logic [31:0]       tx_words
);
    logic              drive_en;
    logic              rd_take;
    logic              wr_take;
    logic [DATA_W-1:0] tx_data;

    fbm_seq #(
        .CMD_CYCLES(CMD_CYCLES),
        .BURST_MAX (BURST_MAX),
        .LEN_W     (LEN_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxf_n    (rxf_n),
        .txe_n    (txe_n),
        .burst_len(burst_len),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .oe_n     (oe_n),
        .drive_en (drive_en),
        .rd_take  (rd_take),
        .wr_take  (wr_take)
    );

    fbm_tx_pattern #(
        .DW(DATA_W)
    ) u_txp (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (wr_take),
        .data_o (tx_data),
        .count_o(tx_words)
    );

    fbm_rx_check #(
        .DW   (DATA_W),
        .ERR_W(ERR_W)
    ) u_rxc (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (rd_take),
        .data_i (data_io),
        .err_o  (err_count),
        .words_o(rx_words)
    );

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign data_io[8*b +: 8] = drive_en ? tx_data[8*b +: 8] : 8'bz;
        assign be_io[b]          = drive_en ? 1'b1 : 1'bz;
    end

endmodule

// File: rtl/fbm_stream_master_chk.sv
module fbm_stream_master_chk #(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rxf_n,
    input logic             txe_n,
    input logic             wr_n,
    input logic             rd_n,
    input logic             oe_n,
    input logic [ERR_W-1:0] err_count,
    input logic [31:0]      rx_words,
    input logic [31:0]      tx_words
);
    p_bus_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !wr_n));

    p_rd_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !oe_n);

    p_oe_after_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> ($past(rd_n) && $past(wr_n)));

    p_rd_follows_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !rxf_n);

    p_rx_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> (rx_words == $past(rx_words) + 32'd1));

    p_rx_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |=> $stable(rx_words));

    p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |=> $stable(err_count));

    p_err_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == '1) |=> (err_count == '1));

    p_wr_follows_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !txe_n);

    p_tx_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> (tx_words == $past(tx_words) + 32'd1));

    p_tx_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |=> $stable(tx_words));

endmodule

bind fbm_stream_master fbm_stream_master_chk #(
    .ERR_W(ERR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxf_n    (rxf_n),
    .txe_n    (txe_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .oe_n     (oe_n),
    .err_count(err_count),
    .rx_words (rx_words),
    .tx_words (tx_words)
);

// File: tb/fbm_stream_master_test.sv
module fbm_stream_master_test;
    localparam int DW    = 32;
    localparam int BMAX  = 1024;
    localparam int ERR_W = 8;
    localparam int LW    = $clog2(BMAX + 1);

    // vector table: kind 0 = read, 1 = write
    localparam int VEC_N = 6;
    localparam int V_KIND [VEC_N] = '{0, 0, 1, 1, 0, 1};
    localparam int V_CNT  [VEC_N] = '{5, 37, 10, 7, 8, 1100};
    localparam int V_LEN  [VEC_N] = '{0, 0, 4, 7, 0, 0};
    localparam int V_BAD  [VEC_N] = '{0, 0, 0, 0, 1, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxf_n = 1'b1;
    logic          txe_n = 1'b1;
    logic [LW-1:0] burst_len = '0;
    logic          wr_n, rd_n, oe_n;
    wire  [DW-1:0] data_io;
    wire  [3:0]    be_io;
    logic [ERR_W-1:0] err_count;
    logic [31:0]   rx_words, tx_words;
    logic [DW-1:0] bdata = '0;

    assign data_io = (oe_n === 1'b0) ? bdata : 'z;
    assign be_io   = (oe_n === 1'b0) ? 4'hF : 'z;

    fbm_stream_master #(.DATA_W(DW), .BURST_MAX(BMAX), .CMD_CYCLES(2), .ERR_W(ERR_W)) uut (
        .clk(clk), .rst_n(rst_n), .rxf_n(rxf_n), .txe_n(txe_n), .burst_len(burst_len),
        .wr_n(wr_n), .rd_n(rd_n), .oe_n(oe_n), .data_io(data_io), .be_io(be_io),
        .err_count(err_count), .rx_words(rx_words), .tx_words(tx_words));

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    // bridge model state
    int rx_avail = 0;
    int tx_space = 0;
    bit corrupt = 1'b0;
    logic [31:0] rx_pat = '0;
    logic [31:0] tx_exp = '0;
    int cyc = 0;
    int flag_cyc = 0;
    int first_rd = -1;
    int first_oe = -1;
    int first_dir = 0;
    int rd_bursts = 0;
    int wr_bursts = 0;
    int cur_len = 0;
    int last_len = 0;
    int max_len = 0;
    bit prev_rd = 1'b0;
    bit prev_oe = 1'b0;
    bit prev_rxf = 1'b1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // bridge model: flags and data set at the falling edge, strobes observed after
    task automatic bridge_loop();
        forever begin
            @(negedge clk);
            cyc++;
            rxf_n = (rx_avail == 0);
            txe_n = (tx_space == 0);
            bdata = (rx_avail > 0 && !corrupt) ? rx_pat : ~rx_pat;
            if (prev_rxf && !rxf_n) flag_cyc = cyc;
            prev_rxf = rxf_n;
            #1;
            if (rst_n) begin
                if (!oe_n && !wr_n) check(1'b0, "R11 oe_n/wr_n overlap", 0, 1);
                if (!oe_n && prev_oe && first_oe < 0) first_oe = cyc;
                if (!oe_n && first_oe < 0) first_oe = cyc;
                prev_oe = !oe_n;
                if (!rd_n) begin
                    if (first_rd < 0) first_rd = cyc;
                    if (first_dir == 0) first_dir = 1;
                    if (!prev_rd) rd_bursts++;
                    rx_avail--;
                    rx_pat++;
                end
                prev_rd = !rd_n;
                if (!wr_n) begin
                    check(data_io == tx_exp[DW-1:0], "R7 write data", data_io, tx_exp);
                    check(be_io == 4'hF, "R7 byte enables", be_io, 15);
                    if (first_dir == 0) first_dir = 2;
                    tx_exp++;
                    tx_space--;
                    cur_len++;
                end else if (cur_len > 0) begin
                    last_len = cur_len;
                    if (cur_len > max_len) max_len = cur_len;
                    wr_bursts++;
                    cur_len = 0;
                end
            end
        end
    endtask

    task automatic wait_quiet();
        while (rx_avail != 0 || tx_space != 0) @(negedge clk);
        repeat (12) @(negedge clk);
        #2;
    endtask

    initial begin
        fork
            bridge_loop();
        join_none
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int rx0, tx0, e0, rb0, wb0;
        int eff, nb, lastb;
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state
        check(wr_n === 1'b1 && rd_n === 1'b1 && oe_n === 1'b1, "R1 strobes in reset", {wr_n, rd_n, oe_n}, 7);
        check(err_count == 0 && rx_words == 0 && tx_words == 0, "R1 counters in reset", rx_words + tx_words + err_count, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        check(wr_n === 1'b1 && rd_n === 1'b1 && oe_n === 1'b1, "R1 strobes after reset", {wr_n, rd_n, oe_n}, 7);

        // R10: both pending right after reset -> read first
        @(posedge clk);
        first_dir = 0;
        rx_avail = 2;
        tx_space = 2;
        wait_quiet();
        check(first_dir == 1, "R10 first choice after reset", first_dir, 1);
        // last burst was a write -> read wins
        @(posedge clk);
        first_dir = 0;
        rx_avail = 2;
        tx_space = 2;
        wait_quiet();
        check(first_dir == 1, "R10 after write burst", first_dir, 1);
        // a lone read, then both -> write wins
        @(posedge clk);
        rx_avail = 1;
        wait_quiet();
        @(posedge clk);
        first_dir = 0;
        rx_avail = 2;
        tx_space = 2;
        wait_quiet();
        check(first_dir == 2, "R10 after read burst", first_dir, 2);

        // table of vectors
        for (int i = 0; i < VEC_N; i++) begin
            rx0 = rx_words; tx0 = tx_words; e0 = err_count;
            rb0 = rd_bursts; wb0 = wr_bursts;
            @(posedge clk);
            max_len = 0;
            first_rd = -1;
            first_oe = -1;
            burst_len = LW'(V_LEN[i]);
            corrupt = V_BAD[i] != 0;
            if (V_KIND[i] == 0) rx_avail = V_CNT[i];
            else tx_space = V_CNT[i];
            wait_quiet();
            corrupt = 1'b0;
            if (V_KIND[i] == 0) begin
                check(rx_words - rx0 == V_CNT[i], "R4 read word count", rx_words - rx0, V_CNT[i]);
                check(rd_bursts - rb0 == 1, "R3 single read burst", rd_bursts - rb0, 1);
                check(err_count - e0 == (V_BAD[i] != 0 ? V_CNT[i] : 0), "R5 mismatch count",
                      err_count - e0, V_BAD[i] != 0 ? V_CNT[i] : 0);
                check(first_rd - flag_cyc == 4, "R2 read strobe latency", first_rd - flag_cyc, 4);
                check(first_oe - flag_cyc == 4, "R2 output enable latency", first_oe - flag_cyc, 4);
            end else begin
                eff = (V_LEN[i] == 0) ? BMAX : V_LEN[i];
                nb = (V_CNT[i] + eff - 1) / eff;
                lastb = V_CNT[i] - (nb - 1) * eff;
                check(tx_words - tx0 == V_CNT[i], "R7 write word count", tx_words - tx0, V_CNT[i]);
                check(wr_bursts - wb0 == nb, "R8 write burst count", wr_bursts - wb0, nb);
                check(last_len == lastb, "R8 short final burst", last_len, lastb);
                check(max_len == ((nb > 1) ? eff : V_CNT[i]), "R8 longest burst", max_len,
                      (nb > 1) ? eff : V_CNT[i]);
            end
        end

        // R4: flag rises inside a read burst, garbage on the bus is not taken
        rx0 = rx_words; e0 = err_count; rb0 = rd_bursts;
        @(posedge clk);
        rx_avail = 3;
        wait_quiet();
        @(posedge clk);
        rx_avail = 4;
        wait_quiet();
        check(rx_words - rx0 == 7, "R4 words across gap", rx_words - rx0, 7);
        check(err_count == e0, "R4 no error from idle-cycle word", err_count, e0);
        check(rd_bursts - rb0 == 2, "R4 burst ends on flag", rd_bursts - rb0, 2);

        // R9: space runs out inside a write burst
        tx0 = tx_words; wb0 = wr_bursts;
        burst_len = '0;
        @(posedge clk);
        tx_space = 3;
        wait_quiet();
        @(posedge clk);
        tx_space = 5;
        wait_quiet();
        check(tx_words - tx0 == 8, "R9 words across space gap", tx_words - tx0, 8);
        check(wr_bursts - wb0 == 2, "R9 burst ends on flag", wr_bursts - wb0, 2);
        check(tx_words == tx_exp, "R9 bridge and master agree", tx_words, tx_exp);

        // R6: saturation of the error counter
        @(posedge clk);
        corrupt = 1'b1;
        rx_avail = 300;
        wait_quiet();
        check(err_count == 255, "R6 saturated", err_count, 255);
        @(posedge clk);
        rx_avail = 5;
        wait_quiet();
        corrupt = 1'b0;
        check(err_count == 255, "R6 stays saturated", err_count, 255);
        check(rx_words == rx_pat, "R5 read words match bridge", rx_words, rx_pat);

        finish_run();
    end

endmodule